// File: doc/BRIEF.md
# Special-Purpose Register File

This block is the special-purpose register file of a small 32-bit RISC core. It serves two kinds of request from the execute stage: a move into a special register and a move out of one. The register address is formed by ORing a base operand with a 16-bit immediate offset. Bits 15:11 of the result select a group and bits 10:0 select a register within that group. Any set bit above bit 15 makes the address unimplemented.

The file holds the system group: version, status, next PC, previous PC, exception PC, exception effective address and exception status. It also holds four read-only configuration words, which are fixed by parameters. It holds the mask and status words of a simple interrupt controller, and the status word also latches the core's interrupt lines.

The two translation-buffer groups and the tick-timer group are not stored here. Requests to them are forwarded on a select, write-strobe and data bundle, and their read data is returned on dedicated inputs. Access is legal only in supervisor mode; a request in user mode is refused and flagged as an illegal instruction. A status write that changes a mode bit affecting address translation raises a one-cycle flush request.

Top module: `spr_unit`

## Requirements
- R1: The address is `base_i | {16'h0, offs_i}`. Group = bits 15:11, number = bits 10:0. Any set bit in 31:16 makes the address unimplemented.
- R2: After reset, the status register reads 0x00008001 (supervisor bit 0 and fixed-one bit 15 set). The next PC reads RESET_NPC, the version reads VER_INIT masked, the interrupt mask and status read 0, and `flush_o` is low.
- R3: A write to the status register (group 0, number 17) always leaves bit 15 set, whatever value was written.
- R4: A legal status write that changes bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) drives `flush_o` high for exactly the following cycle. A status write that changes none of these bits leaves `flush_o` low.
- R5: A write to group 9 number 0 ORs the written value into the interrupt mask; a read returns the mask.
- R6: A write to group 9 number 2 clears each status bit that is set in the written value. Each cycle in which an `irq_i` line is high sets the matching status bit.
- R7: A read of an unimplemented address returns `rd_old_i` unchanged.
- R8: When status bit 0 is clear, a request does not touch the file. In that case a read returns `rd_old_i`, a write changes no register (and so raises no flush), and no external select or write strobe rises.
- R9: The version register (group 0, number 0) is writable, and a read returns the stored value ANDed with 0xFFFF003F.
- R10: Numbers 1 to 4 of group 0 read UPR_VAL, CPUCFG_VAL, DMMUCFG_VAL and IMMUCFG_VAL; writes to them are ignored.
- R11: Group 0 numbers 16, 18, 32, 48 and 64 are plain 32-bit registers (next PC, previous PC, exception PC, exception address, exception status), each read back as written.
- R12: A legal request to group 1, 2 or 10 raises `dtlb_sel_o`, `itlb_sel_o` or `tick_sel_o` respectively, at most one at a time. For a write, `ext_we_o` also rises. `ext_num_o` carries the register number and `ext_wdata_o` the write data. A read returns the matching external read-data input.
- R13: `illegal_o` is high exactly when a read or write request is present and status bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_rd_i | input | 1 | Move-from-register request |
| req_wr_i | input | 1 | Move-to-register request |
| base_i | input | 32 | Base operand of the address |
| offs_i | input | 16 | Immediate offset ORed into the address |
| wdata_i | input | 32 | Write data |
| rd_old_i | input | 32 | Current destination value, returned when nothing is read |
| irq_i | input | NIRQ | Interrupt lines, latched into the status word |
| rdata_o | output | 32 | Read data |
| illegal_o | output | 1 | Request refused in user mode |
| flush_o | output | 1 | One-cycle full translation flush request |
| sr_o | output | 32 | Current status register |
| dtlb_sel_o | output | 1 | Data translation group selected |
| itlb_sel_o | output | 1 | Instruction translation group selected |
| tick_sel_o | output | 1 | Tick timer group selected |
| ext_we_o | output | 1 | Write strobe to the selected external group |
| ext_num_o | output | 11 | Register number within the external group |
| ext_wdata_o | output | 32 | Write data to the external group |
| dtlb_rdata_i | input | 32 | Read data from the data translation group |
| itlb_rdata_i | input | 32 | Read data from the instruction translation group |
| tick_rdata_i | input | 32 | Read data from the tick timer group |

## Verification
The properties assume that the request strobes, address operands and write data are stable around each rising edge. They also assume that `rst_n` is released in step with the clock, because the flush and status checks compare one cycle with the cycle before it. The stimulus changes every input only at the falling edge and keeps the request strobes low between accesses. Once user mode has been entered, the stimulus returns to supervisor mode only through a reset, since no legal write path leads back.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int SPR_W     = 32;
  localparam int GRP_W     = 5;
  localparam int NUM_W     = 11;
  localparam int NPLAIN    = 5;

  localparam logic [GRP_W-1:0] GRP_SYS  = 5'd0;
  localparam logic [GRP_W-1:0] GRP_DTLB = 5'd1;
  localparam logic [GRP_W-1:0] GRP_ITLB = 5'd2;
  localparam logic [GRP_W-1:0] GRP_PIC  = 5'd9;
  localparam logic [GRP_W-1:0] GRP_TICK = 5'd10;

  // status register bit positions
  localparam int SR_SM  = 0;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_FO  = 15;

  localparam logic [SPR_W-1:0] SR_FLUSH_MASK =
    (32'd1 << SR_SM) | (32'd1 << SR_DME) | (32'd1 << SR_IME);
  localparam logic [SPR_W-1:0] SR_RESET     = (32'd1 << SR_SM) | (32'd1 << SR_FO);
  localparam logic [SPR_W-1:0] VER_RD_MASK  = 32'hFFFF_003F;

  typedef enum logic [4:0] {
    T_NONE, T_VER, T_UPR, T_CPUCFG, T_DMMU, T_IMMU,
    T_NPC, T_SR, T_PPC, T_EPCR, T_EEAR, T_ESR,
    T_PICMR, T_PICSR, T_DTLB, T_ITLB, T_TICK
  } spr_tgt_e;

  // plain 32-bit registers, in storage-slot order
  localparam spr_tgt_e PLAIN_TGT [NPLAIN] = '{T_NPC, T_PPC, T_EPCR, T_EEAR, T_ESR};
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
(
  input  logic [SPR_W-1:0] base_i,
  input  logic [15:0]      offs_i,
  output spr_tgt_e         tgt_o,
  output logic [NUM_W-1:0] num_o
);
  logic [SPR_W-1:0] addr;
  logic [GRP_W-1:0] grp;
  logic             hi_clear;

  assign addr     = base_i | {16'h0000, offs_i};
  assign hi_clear = (addr[SPR_W-1:16] == '0);
  assign grp      = addr[15:11];
  assign num_o    = addr[NUM_W-1:0];

  always_comb begin
    tgt_o = T_NONE;
    if (hi_clear) begin
      case (grp)
        GRP_SYS: begin
          case (num_o)
            11'd0:   tgt_o = T_VER;
            11'd1:   tgt_o = T_UPR;
            11'd2:   tgt_o = T_CPUCFG;
            11'd3:   tgt_o = T_DMMU;
            11'd4:   tgt_o = T_IMMU;
            11'd16:  tgt_o = T_NPC;
            11'd17:  tgt_o = T_SR;
            11'd18:  tgt_o = T_PPC;
            11'd32:  tgt_o = T_EPCR;
            11'd48:  tgt_o = T_EEAR;
            11'd64:  tgt_o = T_ESR;
            default: tgt_o = T_NONE;
          endcase
        end
        GRP_DTLB: tgt_o = T_DTLB;
        GRP_ITLB: tgt_o = T_ITLB;
        GRP_PIC: begin
          if (num_o == 11'd0)      tgt_o = T_PICMR;
          else if (num_o == 11'd2) tgt_o = T_PICSR;
        end
        GRP_TICK: tgt_o = T_TICK;
        default:  tgt_o = T_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spr_sysgrp.sv
module spr_sysgrp
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_INIT  = 32'h1234_5678,
  parameter logic [31:0] RESET_NPC = 32'h0000_0100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  spr_tgt_e                     tgt_i,
  input  logic [SPR_W-1:0]             wdata_i,
  output logic [SPR_W-1:0]             ver_o,
  output logic [SPR_W-1:0]             sr_o,
  output logic [NPLAIN-1:0][SPR_W-1:0] plain_o,
  output logic                         flush_o
);
  logic             ver_we, sr_we, flush_d;
  logic [SPR_W-1:0] sr_d;

  assign ver_we  = wr_en_i && (tgt_i == T_VER);
  assign sr_we   = wr_en_i && (tgt_i == T_SR);
  assign sr_d    = wdata_i | (32'd1 << SR_FO);
  assign flush_d = sr_we && ((sr_o ^ wdata_i) & SR_FLUSH_MASK) != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ver_o <= VER_INIT;
    else if (ver_we) ver_o <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_o <= SR_RESET;
    else if (sr_we) sr_o <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_o <= 1'b0;
    else        flush_o <= flush_d;
  end

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    localparam logic [SPR_W-1:0] RST_VAL = (g == 0) ? RESET_NPC : '0;
    logic             we;
    logic [SPR_W-1:0] q;
    assign we = wr_en_i && (tgt_i == PLAIN_TGT[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= wdata_i;
    end
    assign plain_o[g] = q;
  end
endmodule

// File: rtl/spr_pic.sv
module spr_pic
  import spr_pkg::*;
#(
  parameter int NIRQ = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  spr_tgt_e         tgt_i,
  input  logic [SPR_W-1:0] wdata_i,
  input  logic [NIRQ-1:0]  irq_i,
  output logic [SPR_W-1:0] mask_o,
  output logic [SPR_W-1:0] stat_o
);
  logic [SPR_W-1:0] irq_w, set_mask, clr_stat, mask_d, stat_d;

  if (NIRQ < SPR_W) begin : g_pad
    assign irq_w = {{(SPR_W-NIRQ){1'b0}}, irq_i};
  end else begin : g_full
    assign irq_w = irq_i[SPR_W-1:0];
  end

  assign set_mask = (wr_en_i && tgt_i == T_PICMR) ? wdata_i : '0;
  assign clr_stat = (wr_en_i && tgt_i == T_PICSR) ? wdata_i : '0;

  always_comb begin
    mask_d = mask_o | set_mask;
    stat_d = (stat_o & ~clr_stat) | irq_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      stat_o <= '0;
    end else begin
      mask_o <= mask_d;
      stat_o <= stat_d;
    end
  end
endmodule

// File: rtl/spr_unit.sv
module spr_unit
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_INIT    = 32'h1234_5678,
  parameter logic [31:0] UPR_VAL     = 32'h0000_0619,
  parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
  parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0] RESET_NPC   = 32'h0000_0100,
  parameter int          NIRQ        = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd_i,
  input  logic              req_wr_i,
  input  logic [31:0]       base_i,
  input  logic [15:0]       offs_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       rd_old_i,
  input  logic [NIRQ-1:0]   irq_i,
  output logic [31:0]       rdata_o,
  output logic              illegal_o,
  output logic              flush_o,
  output logic [31:0]       sr_o,
  output logic              dtlb_sel_o,
  output logic              itlb_sel_o,
  output logic              tick_sel_o,
  output logic              ext_we_o,
  output logic [10:0]       ext_num_o,
  output logic [31:0]       ext_wdata_o,
  input  logic [31:0]       dtlb_rdata_i,
  input  logic [31:0]       itlb_rdata_i,
  input  logic [31:0]       tick_rdata_i
);
  spr_tgt_e                     tgt;
  logic [NUM_W-1:0]             num;
  logic                         super_mode, any_req, rd_en, wr_en, ext_hit;
  logic [SPR_W-1:0]             ver_q, pic_mask, pic_stat;
  logic [NPLAIN-1:0][SPR_W-1:0] plain;

  spr_decode u_dec (
    .base_i (base_i),
    .offs_i (offs_i),
    .tgt_o  (tgt),
    .num_o  (num)
  );

  assign super_mode = sr_o[SR_SM];
  assign any_req    = req_rd_i | req_wr_i;
  assign illegal_o  = any_req & ~super_mode;
  assign rd_en      = req_rd_i & super_mode;
  assign wr_en      = req_wr_i & super_mode;

  spr_sysgrp #(.VER_INIT(VER_INIT), .RESET_NPC(RESET_NPC)) u_sys (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .tgt_i   (tgt),
    .wdata_i (wdata_i),
    .ver_o   (ver_q),
    .sr_o    (sr_o),
    .plain_o (plain),
    .flush_o (flush_o)
  );

  spr_pic #(.NIRQ(NIRQ)) u_pic (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .tgt_i   (tgt),
    .wdata_i (wdata_i),
    .irq_i   (irq_i),
    .mask_o  (pic_mask),
    .stat_o  (pic_stat)
  );

  // forwarding to the external groups
  assign dtlb_sel_o  = any_req & super_mode & (tgt == T_DTLB);
  assign itlb_sel_o  = any_req & super_mode & (tgt == T_ITLB);
  assign tick_sel_o  = any_req & super_mode & (tgt == T_TICK);
  assign ext_hit     = (tgt == T_DTLB) | (tgt == T_ITLB) | (tgt == T_TICK);
  assign ext_we_o    = wr_en & ext_hit;
  assign ext_num_o   = num;
  assign ext_wdata_o = wdata_i;

  always_comb begin
    rdata_o = rd_old_i;
    if (rd_en) begin
      case (tgt)
        T_VER:    rdata_o = ver_q & VER_RD_MASK;
        T_UPR:    rdata_o = UPR_VAL;
        T_CPUCFG: rdata_o = CPUCFG_VAL;
        T_DMMU:   rdata_o = DMMUCFG_VAL;
        T_IMMU:   rdata_o = IMMUCFG_VAL;
        T_NPC:    rdata_o = plain[0];
        T_SR:     rdata_o = sr_o;
        T_PPC:    rdata_o = plain[1];
        T_EPCR:   rdata_o = plain[2];
        T_EEAR:   rdata_o = plain[3];
        T_ESR:    rdata_o = plain[4];
        T_PICMR:  rdata_o = pic_mask;
        T_PICSR:  rdata_o = pic_stat;
        T_DTLB:   rdata_o = dtlb_rdata_i;
        T_ITLB:   rdata_o = itlb_rdata_i;
        T_TICK:   rdata_o = tick_rdata_i;
        default:  rdata_o = rd_old_i;
      endcase
    end
  end
endmodule

// File: rtl/spr_unit_chk.sv
module spr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_rd_i,
  input logic        req_wr_i,
  input logic [31:0] base_i,
  input logic [15:0] offs_i,
  input logic [31:0] wdata_i,
  input logic [31:0] sr_o,
  input logic        flush_o,
  input logic        illegal_o,
  input logic [2:0]  sels,
  input logic        ext_we_o,
  input logic [31:0] pic_mask
);
  logic sr_wr_legal, sr_wr_change, any_req;

  assign any_req      = req_rd_i || req_wr_i;
  assign sr_wr_legal  = req_wr_i && sr_o[0] && ((base_i | {16'h0, offs_i}) == 32'd17);
  assign sr_wr_change = sr_wr_legal && ((sr_o ^ wdata_i) & 32'h0000_0061) != 32'h0;

  assert_fo_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_legal |=> sr_o[15]);

  assert_flush_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_change |=> flush_o);

  assert_flush_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(sr_wr_change));

  assert_mask_keeps_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pic_mask & $past(pic_mask)) == $past(pic_mask)));

  assert_user_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !sr_o[0]) |-> (illegal_o && !ext_we_o && sels == 3'b000));

  assert_user_sr_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr_i && !sr_o[0]) |=> $stable(sr_o));

  assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  assert_ext_we_needs_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we_o |-> (req_wr_i && sels != 3'b000));

  assert_no_idle_illegal_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |-> !illegal_o);
endmodule

bind spr_unit spr_unit_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_rd_i  (req_rd_i),
  .req_wr_i  (req_wr_i),
  .base_i    (base_i),
  .offs_i    (offs_i),
  .wdata_i   (wdata_i),
  .sr_o      (sr_o),
  .flush_o   (flush_o),
  .illegal_o (illegal_o),
  .sels      ({dtlb_sel_o, itlb_sel_o, tick_sel_o}),
  .ext_we_o  (ext_we_o),
  .pic_mask  (pic_mask)
);

// File: tb/test_spr_unit.sv
module test_spr_unit;
  localparam int NIRQ = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rd_i = 1'b0, req_wr_i = 1'b0;
  logic [31:0] base_i = '0, wdata_i = '0, rd_old_i = '0;
  logic [15:0] offs_i = '0;
  logic [NIRQ-1:0] irq_i = '0;
  logic [31:0] rdata_o, sr_o, ext_wdata_o;
  logic        illegal_o, flush_o, dtlb_sel_o, itlb_sel_o, tick_sel_o, ext_we_o;
  logic [10:0] ext_num_o;
  logic [31:0] dtlb_rdata_i = 32'h0D0D_0D0D;
  logic [31:0] itlb_rdata_i = 32'h1E1E_1E1E;
  logic [31:0] tick_rdata_i = 32'h7A7A_7A7A;

  int  n_checks = 0, n_fails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  spr_unit #(.NIRQ(NIRQ)) i_spr_unit (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] base;
    logic [15:0] offs;
    logic [31:0] data;   // write data, or rd_old for a read
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{1'b0, 32'h0,        16'h0000, 32'h0,          32'h1234_0038, 8'd9},  // R9
    '{1'b0, 32'h0,        16'h0001, 32'h0,          32'h0000_0619, 8'd10}, // R10
    '{1'b1, 32'h0,        16'h0001, 32'hFFFF_FFFF,  32'h0,         8'd10}, // R10
    '{1'b0, 32'h0,        16'h0001, 32'h0,          32'h0000_0619, 8'd10}, // R10
    '{1'b0, 32'h0,        16'h0002, 32'h0,          32'h0000_0020, 8'd10}, // R10
    '{1'b0, 32'h0,        16'h0003, 32'h0,          32'h0000_0018, 8'd10}, // R10
    '{1'b0, 32'h0,        16'h0004, 32'h0,          32'h0000_0018, 8'd10}, // R10
    '{1'b1, 32'h10,       16'h0000, 32'hCAFE_0000,  32'h0,         8'd1},  // R1
    '{1'b0, 32'h0,        16'h0010, 32'h0,          32'hCAFE_0000, 8'd11}, // R11
    '{1'b1, 32'h0,        16'h0012, 32'h1111_2222,  32'h0,         8'd11}, // R11
    '{1'b0, 32'h0,        16'h0012, 32'h0,          32'h1111_2222, 8'd11}, // R11
    '{1'b1, 32'h20,       16'h0000, 32'hA5A5_A5A5,  32'h0,         8'd1},  // R1
    '{1'b0, 32'h0,        16'h0020, 32'h0,          32'hA5A5_A5A5, 8'd11}, // R11
    '{1'b1, 32'h0,        16'h0030, 32'h0BAD_0BAD,  32'h0,         8'd11}, // R11
    '{1'b0, 32'h30,       16'h0000, 32'h0,          32'h0BAD_0BAD, 8'd1},  // R1
    '{1'b1, 32'h0,        16'h0040, 32'h0000_0F0F,  32'h0,         8'd11}, // R11
    '{1'b0, 32'h0,        16'h0040, 32'h0,          32'h0000_0F0F, 8'd11}, // R11
    '{1'b1, 32'h0,        16'h0000, 32'hFFFF_FFFF,  32'h0,         8'd9},  // R9
    '{1'b0, 32'h0,        16'h0000, 32'h0,          32'hFFFF_003F, 8'd9},  // R9
    '{1'b1, 32'h0,        16'h0011, 32'h0000_0001,  32'h0,         8'd3},  // R3
    '{1'b0, 32'h0,        16'h0011, 32'h0,          32'h0000_8001, 8'd3},  // R3
    '{1'b1, 32'h0,        16'h4800, 32'h0000_000F,  32'h0,         8'd5},  // R5
    '{1'b1, 32'h0,        16'h4800, 32'h0000_00F0,  32'h0,         8'd5},  // R5
    '{1'b0, 32'h0,        16'h4800, 32'h0,          32'h0000_00FF, 8'd5},  // R5
    '{1'b0, 32'h0,        16'h0005, 32'hDEAD_BEEF,  32'hDEAD_BEEF, 8'd7},  // R7
    '{1'b0, 32'h0,        16'h4801, 32'h0123_4567,  32'h0123_4567, 8'd7},  // R7
    '{1'b0, 32'h0001_0000,16'h0000, 32'h55AA_55AA,  32'h55AA_55AA, 8'd1},  // R1
    '{1'b0, 32'h0,        16'h0A05, 32'h0,          32'h0D0D_0D0D, 8'd12}, // R12
    '{1'b0, 32'h0,        16'h1200, 32'h0,          32'h1E1E_1E1E, 8'd12}, // R12
    '{1'b0, 32'h0,        16'h5001, 32'h0,          32'h7A7A_7A7A, 8'd12}  // R12
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    base_i = b; offs_i = o; wdata_i = d; req_wr_i = 1'b1;
    @(negedge clk);
    req_wr_i = 1'b0;
    #1;
  endtask

  task automatic do_read(input logic [31:0] b, input logic [15:0] o, input logic [31:0] old,
                         input logic [31:0] exp, input string req);
    @(negedge clk);
    base_i = b; offs_i = o; rd_old_i = old; req_rd_i = 1'b1;
    #1;
    chk(req, rdata_o, exp);
    req_rd_i = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2: reset state
    chk("R2 flush", {31'h0, flush_o}, 32'h0);
    do_read(32'h0, 16'h0011, 32'h0, 32'h0000_8001, "R2 sr");
    do_read(32'h0, 16'h0010, 32'h0, 32'h0000_0100, "R2 npc");
    do_read(32'h0, 16'h4802, 32'h0, 32'h0, "R2 picsr");

    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) do_write(VT[i].base, VT[i].offs, VT[i].data);
      else do_read(VT[i].base, VT[i].offs, VT[i].data, VT[i].exp,
                   $sformatf("R%0d row %0d", VT[i].req, i));
    end

    // R6: irq sets status, a write clears selected bits
    @(negedge clk); irq_i = 20'h00005;
    @(negedge clk); irq_i = '0;
    do_read(32'h0, 16'h4802, 32'h0, 32'h0000_0005, "R6 set");
    do_write(32'h0, 16'h4802, 32'h0000_0001);
    do_read(32'h0, 16'h4802, 32'h0, 32'h0000_0004, "R6 clear");

    // R12: write forwarded to instruction translation group, number 0x234
    @(negedge clk);
    base_i = 32'h0; offs_i = 16'h1234; wdata_i = 32'h77; req_wr_i = 1'b1;
    #1;
    chk("R12 sels", {29'h0, dtlb_sel_o, itlb_sel_o, tick_sel_o}, 32'h2);
    chk("R12 we", {31'h0, ext_we_o}, 32'h1);
    chk("R12 num", {21'h0, ext_num_o}, 32'h234);
    chk("R12 wdata", ext_wdata_o, 32'h77);
    @(negedge clk); req_wr_i = 1'b0;

    // R4: flush pulse on a translation-enable change, none on a repeat
    do_write(32'h0, 16'h0011, 32'h0000_8021);
    chk("R4 pulse", {31'h0, flush_o}, 32'h1);
    @(negedge clk); #1;
    chk("R4 one cycle", {31'h0, flush_o}, 32'h0);
    do_write(32'h0, 16'h0011, 32'h0000_8021);
    chk("R4 no change", {31'h0, flush_o}, 32'h0);
    do_read(32'h0, 16'h0011, 32'h0, 32'h0000_8021, "R3 sr");

    // leave supervisor mode (bit 0 cleared): R4 pulse, R3 FO still set
    do_write(32'h0, 16'h0011, 32'h0000_0020);
    chk("R4 sm change", {31'h0, flush_o}, 32'h1);
    chk("R3 fo", sr_o, 32'h0000_8020);

    // R8 / R13: user mode requests are refused
    @(negedge clk);
    base_i = 32'h0; offs_i = 16'h0010; rd_old_i = 32'h1357_2468; req_rd_i = 1'b1;
    #1;
    chk("R8 rdata", rdata_o, 32'h1357_2468);
    chk("R13 illegal", {31'h0, illegal_o}, 32'h1);
    req_rd_i = 1'b0;
    #1;
    chk("R13 idle", {31'h0, illegal_o}, 32'h0);
    @(negedge clk);
    offs_i = 16'h0800; wdata_i = 32'h9; req_wr_i = 1'b1;
    #1;
    chk("R8 ext", {30'h0, ext_we_o, dtlb_sel_o}, 32'h0);
    @(negedge clk); req_wr_i = 1'b0;
    do_write(32'h0, 16'h0011, 32'h0000_8061);
    chk("R8 no flush", {31'h0, flush_o}, 32'h0);
    chk("R8 sr kept", sr_o, 32'h0000_8020);

    // R2: reset again in the middle of use
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 flush after", {31'h0, flush_o}, 32'h0);
    do_read(32'h0, 16'h0011, 32'h0, 32'h0000_8001, "R2 sr after");
    do_read(32'h0, 16'h0010, 32'h0, 32'h0000_0100, "R2 npc after");
    do_read(32'h0, 16'h4800, 32'h0, 32'h0, "R2 mask after");
    do_read(32'h0, 16'h0000, 32'h0, 32'h1234_0038, "R2 ver after");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule